// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the control side of a clocked burst read port on a memory with a 32-bit data path. When the chip is selected and the address-valid strobe is sampled low, it records the start address and the configuration in force. It then waits a programmable number of clock cycles before it presents the first word address to the storage array. After that it walks the address linearly, one doubleword per clock, and wraps inside the aligned group of four. An active-low end-of-group marker pulses for one clock on either the last or the next-to-last transfer of every group, as the configuration selects.

The storage array is a separate synchronous lookup driven by `rd_addr`. `dvalid` says that the sequencer is presenting burst data, and `data_oe` enables the data pads. A high chip select ends the burst at once. A fresh address-valid strobe during a burst starts the whole sequence again from the new address.

Top module: `sbr_burst_seq`

## Requirements
- R1: Out of reset, and until the first burst starts, `dvalid` = 0, `data_oe` = 0 and `ind_n` = 1.
- R2: A capture happens on a rising `clk` edge that sees `ce_n` = 0 and `adv_n` = 0, when either `adv_n` was 1 at the edge before or the sequencer is idle. Holding `adv_n` low over later edges causes no further capture.
- R3: With a latency code C in 1..7 on `cfg_lat` (the field that occupies bits 13..10 of the configuration register image), the latency is L = C + 2 cycles. `dvalid` stays 0 after capture edges 1 to L-1 that follow the capture, and becomes 1 after edge L.
- R4: Latency codes 0 and 8..15 are reserved and give L = 9.
- R5: Beat n (n = 0, 1, ...) is presented after edge L+n. `rd_addr` keeps the captured upper bits, and its low 2 bits equal (captured low 2 bits + n) mod 4.
- R6: `ind_n` is 0 for exactly one cycle on the beats where n mod 4 = 3 when `cfg_sel` = 0, and where n mod 4 = 2 when `cfg_sel` = 1. Otherwise `ind_n` is 1.
- R7: `cfg_lat` and `cfg_sel` are sampled only at the capture edge. Changing them later has no effect on the running burst.
- R8: A rising edge that sees `ce_n` = 1 returns the sequencer to idle. After that edge `dvalid` = 0 and `ind_n` = 1, and the burst does not resume when `ce_n` goes low again without a new capture.
- R9: `data_oe` = `dvalid` AND NOT `oe_n`. With `oe_n` = 1 the beats still advance.
- R10: A capture during a running burst drops `dvalid` after that edge, reloads the latency from the new configuration and restarts at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip select; high aborts any burst |
| adv_n | input | 1 | Active-low address-valid strobe |
| oe_n | input | 1 | Active-low output enable for the data pads |
| addr | input | AW | Burst start address (doubleword units) |
| cfg_lat | input | 4 | Initial latency code from the configuration image |
| cfg_sel | input | 1 | Marker position: 0 last beat of group, 1 next-to-last |
| rd_addr | output | AW | Doubleword address presented to the storage array |
| dvalid | output | 1 | Burst data is being presented |
| data_oe | output | 1 | Data pad output enable |
| ind_n | output | 1 | Active-low end-of-group marker |

## Verification
The hardest situations to reach are the ones where the strobe or the configuration moves while the sequencer is in the middle of an operation. These are `adv_n` held low across the whole latency window, a second capture in the middle of the beats, and configuration changes right after the capture edge. The directed tasks drive these inputs one cycle after a known capture edge. They then count edges from that capture to show that neither the latency nor the address was taken again. Chip-select aborts are placed inside the latency window, where a resumed count would otherwise look like a correct late burst.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_WAIT = 2'd1,
      SQ_BEAT = 2'd2
   } sq_state_t;

   localparam int unsigned LAT_FW  = 4;
   localparam logic [LAT_FW-1:0] LAT_MAX = 4'd9;

   // Code 1..7 maps to code+2 cycles; all other codes take the longest wait.
   function automatic logic [LAT_FW-1:0] lat_decode(input logic [LAT_FW-1:0] code);
      if (code >= 4'd1 && code <= 4'd7)
         return code + 4'd2;
      else
         return LAT_MAX;
   endfunction

endpackage

// File: rtl/sbr_lat_ctr.sv
module sbr_lat_ctr #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          load,
   input  logic [CW-1:0] ld_val,
   output logic          expire
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (load)
         cnt_q <= ld_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expire = (cnt_q == CW'(1));

   // R3: the expiry strobe lasts a single cycle unless the counter is reloaded
   p_expire_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !load && !clr) |=> !expire);

endmodule

// File: rtl/sbr_wrap_addr.sv
module sbr_wrap_addr #(
   parameter int unsigned AW        = 20,
   parameter int unsigned BURST_LEN = 4,
   localparam int unsigned OFF_W    = $clog2(BURST_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic [AW-1:0]    addr_in,
   output logic [AW-1:0]    rd_addr,
   output logic [OFF_W-1:0] beat
);

   logic [AW-1:0]    base_q;
   logic [OFF_W-1:0] beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
      end else if (load) begin
         base_q <= addr_in;
         beat_q <= '0;
      end else if (step) begin
         beat_q <= beat_q + 1'b1;
      end
   end

   // Offset sum is OFF_W bits wide so it wraps inside the aligned group.
   assign rd_addr = {base_q[AW-1:OFF_W], OFF_W'(base_q[OFF_W-1:0] + beat_q)};
   assign beat    = beat_q;

   // R5: the group base never moves unless a new capture arrives
   p_base_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && $past(!load)) |-> rd_addr[AW-1:OFF_W] == $past(rd_addr[AW-1:OFF_W]));

endmodule

// File: rtl/sbr_ind.sv
module sbr_ind #(
   parameter int unsigned BURST_LEN = 4,
   localparam int unsigned OFF_W    = $clog2(BURST_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             sel,
   input  logic [OFF_W-1:0] beat,
   output logic             ind_n
);

   localparam logic [OFF_W-1:0] LAST_B   = OFF_W'(BURST_LEN - 1);
   localparam logic [OFF_W-1:0] PENULT_B = OFF_W'(BURST_LEN - 2);

   logic [OFF_W-1:0] target;

   assign target = sel ? PENULT_B : LAST_B;
   assign ind_n  = !(active && (beat == target));

   // R6: the marker is never low on two consecutive cycles
   p_ind_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ind_n |=> ind_n);

endmodule

// File: rtl/sbr_burst_seq.sv
module sbr_burst_seq
   import sbr_pkg::*;
#(
   parameter int unsigned AW        = 20,
   parameter int unsigned BURST_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ce_n,
   input  logic          adv_n,
   input  logic          oe_n,
   input  logic [AW-1:0] addr,
   input  logic [3:0]    cfg_lat,
   input  logic          cfg_sel,
   output logic [AW-1:0] rd_addr,
   output logic          dvalid,
   output logic          data_oe,
   output logic          ind_n
);

   localparam int unsigned OFF_W = $clog2(BURST_LEN);

   generate
      if (BURST_LEN < 2 || (1 << OFF_W) != BURST_LEN || AW <= OFF_W) begin : g_bad_cfg
         $error("sbr_burst_seq: BURST_LEN must be a power of two >= 2 and below 2**AW");
      end
   endgenerate

   sq_state_t        state_q;
   logic             adv_prev_n;
   logic             sel_q;
   logic             cap;
   logic             expire;
   logic             step;
   logic [OFF_W-1:0] beat;

   assign cap  = !ce_n && !adv_n && (adv_prev_n || state_q == SQ_IDLE);
   assign step = (state_q == SQ_BEAT) && !ce_n && !cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= SQ_IDLE;
         adv_prev_n <= 1'b1;
         sel_q      <= 1'b0;
      end else begin
         adv_prev_n <= adv_n;
         if (ce_n) begin
            state_q <= SQ_IDLE;
         end else if (cap) begin
            state_q <= SQ_WAIT;
            sel_q   <= cfg_sel;
         end else if (state_q == SQ_WAIT && expire) begin
            state_q <= SQ_BEAT;
         end
      end
   end

   sbr_lat_ctr #(.CW(LAT_FW)) u_lat (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ce_n),
      .load   (cap),
      .ld_val (lat_decode(cfg_lat)),
      .expire (expire)
   );

   sbr_wrap_addr #(.AW(AW), .BURST_LEN(BURST_LEN)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cap),
      .step    (step),
      .addr_in (addr),
      .rd_addr (rd_addr),
      .beat    (beat)
   );

   sbr_ind #(.BURST_LEN(BURST_LEN)) u_ind (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (state_q == SQ_BEAT),
      .sel    (sel_q),
      .beat   (beat),
      .ind_n  (ind_n)
   );

   assign dvalid  = (state_q == SQ_BEAT);
   assign data_oe = dvalid && !oe_n;

   // R8: a deselect edge leaves the outputs idle
   p_idle_after_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |=> (!dvalid && ind_n));

   // R10: a capture always reopens the latency window
   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> !dvalid);

   // R5: each beat advances the offset by one inside the group
   p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && !ce_n && !cap) |=>
         (dvalid && rd_addr[OFF_W-1:0] == OFF_W'($past(rd_addr[OFF_W-1:0]) + 1'b1)));

   // R2: an address strobe held low does not stop the latency from completing
   p_hold_no_recap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_WAIT && expire && !ce_n && !adv_n && !adv_prev_n) |=> dvalid);

   // R6: the marker only appears while burst data is presented
   p_ind_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ind_n |-> dvalid);

endmodule

// File: tb/sim_sbr_burst_seq.sv
module sim_sbr_burst_seq;

   localparam int CLK_P = 10;
   localparam int AW    = 20;

   logic          clk = 1'b0;
   logic          rst_n, ce_n, adv_n, oe_n, cfg_sel;
   logic [AW-1:0] addr;
   logic [3:0]    cfg_lat;
   logic [AW-1:0] rd_addr;
   logic          dvalid, data_oe, ind_n;

   int nvec = 0;
   int nerr = 0;

   always #(CLK_P/2) clk = ~clk;

   sbr_burst_seq #(.AW(AW), .BURST_LEN(4)) u0 (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .oe_n(oe_n),
      .addr(addr), .cfg_lat(cfg_lat), .cfg_sel(cfg_sel),
      .rd_addr(rd_addr), .dvalid(dvalid), .data_oe(data_oe), .ind_n(ind_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   function automatic int exp_lat(input logic [3:0] code);
      return (code >= 4'd1 && code <= 4'd7) ? int'(code) + 2 : 9;
   endfunction

   task automatic capture(input logic [AW-1:0] a, input logic [3:0] code, input logic sel);
      ce_n = 1'b0; adv_n = 1'b0; addr = a; cfg_lat = code; cfg_sel = sel;
      tick;
      adv_n = 1'b1;
   endtask

   task automatic wait_latency(input string req, input int lat);
      for (int i = 1; i < lat; i++) begin
         tick;
         check(req, dvalid, 1'b0);
      end
      tick;
      check(req, dvalid, 1'b1);
   endtask

   task automatic check_beats(input string req, input logic [AW-1:0] a,
                              input logic sel, input int n);
      for (int k = 0; k < n; k++) begin
         check({req, " addr R5"}, rd_addr, {a[AW-1:2], 2'(a[1:0] + 2'(k))});
         check({req, " ind R6"}, ind_n, ((k % 4) == (sel ? 2 : 3)) ? 1'b0 : 1'b1);
         check({req, " oe R9"}, data_oe, !oe_n);
         tick;
      end
   endtask

   task automatic go_idle;
      ce_n = 1'b1; adv_n = 1'b1;
      tick;
      check("R8 dvalid", dvalid, 1'b0);
      check("R8 ind", ind_n, 1'b1);
      tick;
   endtask

   task automatic t_reset;
      rst_n = 1'b0; ce_n = 1'b1; adv_n = 1'b1; oe_n = 1'b0;
      addr = '0; cfg_lat = 4'd1; cfg_sel = 1'b0;
      repeat (3) tick;
      rst_n = 1'b1;
      tick;
      check("R1 dvalid", dvalid, 1'b0);
      check("R1 data_oe", data_oe, 1'b0);
      check("R1 ind", ind_n, 1'b1);
   endtask

   task automatic t_latency_codes;
      for (int c = 1; c <= 7; c++) begin
         capture(20'h12340 + AW'(c * 16), 4'(c), 1'b0);
         wait_latency("R3 latency", exp_lat(4'(c)));
         check_beats("R3", 20'h12340 + AW'(c * 16), 1'b0, 8);
         go_idle;
      end
   endtask

   task automatic t_reserved;
      logic [3:0] codes [3] = '{4'd0, 4'd8, 4'd15};
      foreach (codes[i]) begin
         capture(20'h0F008, codes[i], 1'b1);
         wait_latency("R4 reserved latency", 9);
         check_beats("R4", 20'h0F008, 1'b1, 4);
         go_idle;
      end
   endtask

   task automatic t_offset_sel;
      capture(20'hABCD2, 4'd2, 1'b1);
      wait_latency("R3 offset", 4);
      check_beats("R5 offset", 20'hABCD2, 1'b1, 9);
      go_idle;
      capture(20'h55557, 4'd4, 1'b0);
      wait_latency("R3 offset", 6);
      check_beats("R5 offset", 20'h55557, 1'b0, 6);
      go_idle;
   endtask

   task automatic t_cfg_latched;
      capture(20'h00100, 4'd1, 1'b0);
      cfg_lat = 4'd7; cfg_sel = 1'b1;
      wait_latency("R7 latency kept", 3);
      check_beats("R7", 20'h00100, 1'b0, 8);
      go_idle;
   endtask

   task automatic t_adv_hold;
      ce_n = 1'b0; adv_n = 1'b0; addr = 20'h2222C; cfg_lat = 4'd3; cfg_sel = 1'b0;
      tick;
      addr = 20'h77771;
      wait_latency("R2 held strobe", 5);
      check_beats("R2", 20'h2222C, 1'b0, 5);
      go_idle;
   endtask

   task automatic t_oe;
      oe_n = 1'b1;
      capture(20'h30004, 4'd1, 1'b0);
      wait_latency("R9 latency", 3);
      check_beats("R9 oe high", 20'h30004, 1'b0, 5);
      oe_n = 1'b0;
      #1;
      check("R9 oe low", data_oe, 1'b1);
      go_idle;
   endtask

   task automatic t_restart;
      capture(20'h40000, 4'd3, 1'b0);
      wait_latency("R10 first", 5);
      check_beats("R10 first", 20'h40000, 1'b0, 2);
      capture(20'h4100E, 4'd1, 1'b1);
      check("R10 drop", dvalid, 1'b0);
      wait_latency("R10 reload", 3);
      check_beats("R10 new", 20'h4100E, 1'b1, 6);
      go_idle;
   endtask

   task automatic t_abort_wait;
      capture(20'h60000, 4'd7, 1'b0);
      tick; tick;
      ce_n = 1'b1;
      tick;
      check("R8 abort", dvalid, 1'b0);
      ce_n = 1'b0;
      for (int i = 0; i < 12; i++) begin
         tick;
         check("R8 no resume", dvalid, 1'b0);
      end
      go_idle;
   endtask

   initial begin
      t_reset;
      t_latency_codes;
      t_reserved;
      t_offset_sel;
      t_cfg_latched;
      t_adv_hold;
      t_oe;
      t_restart;
      t_abort_wait;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nvec++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

endmodule